// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a page directory entry and then a page table entry from memory, one request at a time. A requester offers the linear address together with a write flag and a user flag over a valid/ready handshake. The walker fetches the entries through a single 32-bit memory port with a request/acknowledge protocol and returns either the physical address or a fault with its cause, as a one-cycle response pulse.

Besides translating, the walker writes back the accessed bit of every entry it uses and the dirty bit of a page table entry on a write access. The entry is written back only when one of these bits actually changes. A directory entry with its page-size bit set maps a 4 MB frame and ends the walk early, without a table read. When the paging-enable input is low, the request passes through untranslated. A faulting linear address is kept in a fault-address register until the next fault replaces it.

The controller has seven states. IDLE accepts a request and goes to DIR_RD, or to DONE when paging is off. DIR_RD reads the directory entry and goes to FAULT on a missing or forbidden entry, to DIR_WB when the accessed bit must be set, to DONE for a 4 MB page, and otherwise to TBL_RD. DIR_WB writes the entry and goes to DONE for a 4 MB page or to TBL_RD. TBL_RD reads the table entry and goes to FAULT, to TBL_WB when a bit must change, or to DONE. TBL_WB writes the entry and goes to DONE. DONE and FAULT each present the response for one cycle and return to IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: With `pg_enable` low at acceptance, the response gives `rsp_phys` equal to `req_lin`, no fault, and makes no memory access.
- R2: The directory entry is read at {`dir_frame`, linear bits 31:22, 2'b00}. The table entry is read at {directory entry bits 31:12, linear bits 21:12, 2'b00}.
- R3: For a 4 KB page, `rsp_phys` is {table entry bits 31:12, linear bits 11:0}.
- R4: A present, permitted directory entry with bit 7 (page size) set gives `rsp_phys` = {entry bits 31:22, linear bits 21:0}, and no table entry is read.
- R5: An entry with bit 0 (present) clear ends the walk with `rsp_fault` high and `rsp_cause` = 2'b01, and `fault_addr` holds the request's linear address while the response is shown.
- R6: A user access (`req_user` high) to an entry with bit 2 clear, or a write access to an entry with bit 1 clear, ends the walk with `rsp_cause` = 2'b10 and leaves that entry unmodified in memory.
- R7: The walker sets bit 5 (accessed) of each entry it uses by writing back the read value with that bit set, writes nothing when the bit is already set, and never clears it.
- R8: On a write access the walker sets bit 6 (dirty) of the table entry. It never sets bit 6 on a read access or in a directory entry.
- R9: `req_ready` is high only while idle. Only one walk is in progress at a time. `rsp_valid` is a one-cycle pulse. A memory request stays asserted with a stable address until acknowledged.
- R10: `fault_addr` resets to zero and keeps its value across successful translations until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_enable | input | 1 | Translation on when high, sampled at acceptance |
| dir_frame | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Entry value written back |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | 00 none, 01 not present, 10 protection |
| rsp_phys | output | 32 | Translated physical address |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
If the walk state is wrong, the order or addresses of memory accesses change within the same walk. A missing table read after a small-page directory entry, or an extra read after a large one, shows up as a wrong read count or address before the response arrives. A wrong latched entry shows in `rsp_phys` or in the written-back entry value at that walk's response. Stale accessed or dirty handling appears only on a later walk, as a write that should not occur or a missing one, so the bench repeats translations of the same page and checks the write count and the stored entry after each one.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int ENT_W      = 32;
    localparam int OFF_W      = 12;
    localparam int IDX_W      = 10;
    localparam int BIG_OFF_W  = OFF_W + IDX_W;
    localparam int FRAME_W    = PA_W - OFF_W;
    localparam int BIG_W      = PA_W - BIG_OFF_W;
    localparam int ENT_BYTE_W = 2;

    localparam int B_PRES  = 0;
    localparam int B_RW    = 1;
    localparam int B_USER  = 2;
    localparam int B_ACC   = 5;
    localparam int B_DIRTY = 6;
    localparam int B_PSIZE = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WB,
        ST_DONE,
        ST_FAULT
    } walk_st_t;

    typedef enum logic [1:0] {
        FC_NONE    = 2'b00,
        FC_NOTPRES = 2'b01,
        FC_PROT    = 2'b10
    } fault_cause_t;
endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
    input  logic is_write,
    input  logic is_user,
    input  logic p_bit,
    input  logic rw_bit,
    input  logic us_bit,
    output logic present,
    output logic allow
);
    always_comb begin
        present = p_bit;
        allow   = (!is_user || us_bit) && (!is_write || rw_bit);
    end
endmodule

// File: rtl/pgwalk_upd.sv
module pgwalk_upd
    import pgwalk_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic             set_dirty,
    output logic [ENT_W-1:0] new_entry,
    output logic             changed
);
    always_comb begin
        new_entry          = entry;
        new_entry[B_ACC]   = 1'b1;
        if (set_dirty) begin
            new_entry[B_DIRTY] = 1'b1;
        end
        changed = (new_entry != entry);
    end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter bit LARGE_PAGES = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_enable,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_lin,
    input  logic               req_write,
    input  logic               req_user,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [ENT_W-1:0]   mem_wdata,
    input  logic               mem_ack,
    input  logic [FRAME_W-1:0] rd_frame,
    input  logic               rd_ps_raw,
    input  logic               rd_present,
    input  logic               rd_allow,
    input  logic [ENT_W-1:0]   upd_entry,
    input  logic               upd_changed,
    output logic               set_dirty,
    output logic               chk_write,
    output logic               chk_user,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause,
    output logic [PA_W-1:0]    rsp_phys,
    output logic               fault_take,
    output logic [VA_W-1:0]    fault_lin
);
    walk_st_t             state, state_n;
    logic [VA_W-1:0]      lin_q;
    logic                 wr_q, usr_q, big_q;
    logic [FRAME_W-1:0]   dir_q;
    logic [FRAME_W-1:0]   tbl_q;
    logic [ENT_W-1:0]     ent_q;
    logic [PA_W-1:0]      phys_q;
    fault_cause_t         cause_q;
    logic                 rd_big;
    logic                 rd_ok;

    generate
        if (LARGE_PAGES) begin : g_big
            assign rd_big = rd_ps_raw;
        end else begin : g_small
            assign rd_big = 1'b0;
        end
    endgenerate

    assign rd_ok = rd_present && rd_allow;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_n = pg_enable ? ST_DIR_RD : ST_DONE;
                end
            end
            ST_DIR_RD: begin
                if (mem_ack) begin
                    if (!rd_ok)           state_n = ST_FAULT;
                    else if (upd_changed) state_n = ST_DIR_WB;
                    else if (rd_big)      state_n = ST_DONE;
                    else                  state_n = ST_TBL_RD;
                end
            end
            ST_DIR_WB: begin
                if (mem_ack) begin
                    state_n = big_q ? ST_DONE : ST_TBL_RD;
                end
            end
            ST_TBL_RD: begin
                if (mem_ack) begin
                    if (!rd_ok)           state_n = ST_FAULT;
                    else if (upd_changed) state_n = ST_TBL_WB;
                    else                  state_n = ST_DONE;
                end
            end
            ST_TBL_WB: begin
                if (mem_ack) begin
                    state_n = ST_DONE;
                end
            end
            ST_DONE:  state_n = ST_IDLE;
            ST_FAULT: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            big_q   <= 1'b0;
            dir_q   <= '0;
            tbl_q   <= '0;
            ent_q   <= '0;
            phys_q  <= '0;
            cause_q <= FC_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q   <= req_lin;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        dir_q   <= dir_frame;
                        big_q   <= 1'b0;
                        cause_q <= FC_NONE;
                        phys_q  <= req_lin;
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        ent_q  <= upd_entry;
                        tbl_q  <= rd_frame;
                        big_q  <= rd_big;
                        phys_q <= {rd_frame[FRAME_W-1 -: BIG_W], lin_q[BIG_OFF_W-1:0]};
                        if (!rd_present)    cause_q <= FC_NOTPRES;
                        else if (!rd_allow) cause_q <= FC_PROT;
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        ent_q  <= upd_entry;
                        phys_q <= {rd_frame, lin_q[OFF_W-1:0]};
                        if (!rd_present)    cause_q <= FC_NOTPRES;
                        else if (!rd_allow) cause_q <= FC_PROT;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = ent_q;
        set_dirty  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_fault  = 1'b0;
        rsp_cause  = FC_NONE;
        rsp_phys   = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_DIR_RD, ST_DIR_WB: begin
                mem_req  = 1'b1;
                mem_we   = (state == ST_DIR_WB);
                mem_addr = {dir_q, lin_q[VA_W-1 -: IDX_W], {ENT_BYTE_W{1'b0}}};
            end
            ST_TBL_RD, ST_TBL_WB: begin
                mem_req   = 1'b1;
                mem_we    = (state == ST_TBL_WB);
                mem_addr  = {tbl_q, lin_q[BIG_OFF_W-1 -: IDX_W], {ENT_BYTE_W{1'b0}}};
                set_dirty = (state == ST_TBL_RD) && wr_q;
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_phys  = phys_q;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_cause = cause_q;
            end
            default: begin
            end
        endcase
    end

    assign chk_write  = wr_q;
    assign chk_user   = usr_q;
    assign fault_take = (state_n == ST_FAULT) && (state != ST_FAULT);
    assign fault_lin  = lin_q;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[B_ACC]); // R7

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_cause != FC_NONE); // R5

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R9
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter bit LARGE_PAGES = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_enable,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_lin,
    input  logic               req_write,
    input  logic               req_user,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [ENT_W-1:0]   mem_wdata,
    input  logic               mem_ack,
    input  logic [ENT_W-1:0]   mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_cause,
    output logic [PA_W-1:0]    rsp_phys,
    output logic [VA_W-1:0]    fault_addr
);
    logic             rd_present, rd_allow;
    logic [ENT_W-1:0] upd_entry;
    logic             upd_changed;
    logic             set_dirty, chk_write, chk_user;
    logic             fault_take;
    logic [VA_W-1:0]  fault_lin;
    logic [VA_W-1:0]  fault_addr_q;

    pgwalk_perm u_perm (
        .is_write (chk_write),
        .is_user  (chk_user),
        .p_bit    (mem_rdata[B_PRES]),
        .rw_bit   (mem_rdata[B_RW]),
        .us_bit   (mem_rdata[B_USER]),
        .present  (rd_present),
        .allow    (rd_allow)
    );

    pgwalk_upd u_upd (
        .entry     (mem_rdata),
        .set_dirty (set_dirty),
        .new_entry (upd_entry),
        .changed   (upd_changed)
    );

    pgwalk_fsm #(.LARGE_PAGES(LARGE_PAGES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pg_enable   (pg_enable),
        .dir_frame   (dir_frame),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_lin     (req_lin),
        .req_write   (req_write),
        .req_user    (req_user),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .rd_frame    (mem_rdata[ENT_W-1 -: FRAME_W]),
        .rd_ps_raw   (mem_rdata[B_PSIZE]),
        .rd_present  (rd_present),
        .rd_allow    (rd_allow),
        .upd_entry   (upd_entry),
        .upd_changed (upd_changed),
        .set_dirty   (set_dirty),
        .chk_write   (chk_write),
        .chk_user    (chk_user),
        .rsp_valid   (rsp_valid),
        .rsp_fault   (rsp_fault),
        .rsp_cause   (rsp_cause),
        .rsp_phys    (rsp_phys),
        .fault_take  (fault_take),
        .fault_lin   (fault_lin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_addr_q <= '0;
        end else if (fault_take) begin
            fault_addr_q <= fault_lin;
        end
    end

    assign fault_addr = fault_addr_q;

    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> fault_addr == fault_lin); // R5

    AST_FAULT_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> $stable(fault_addr)); // R10
endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;
    localparam time CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] lin;
        logic        wr;
        logic        usr;
        logic [31:0] phys;
        logic [1:0]  cause;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0040_3123, 1'b0, 1'b1, 32'h00AB_C123, 2'b00},
        '{32'h0040_4000, 1'b0, 1'b0, 32'h0000_0000, 2'b01},
        '{32'h0040_5777, 1'b1, 1'b1, 32'h0000_0000, 2'b10},
        '{32'h0040_5777, 1'b0, 1'b1, 32'h0055_5777, 2'b00},
        '{32'h0040_6010, 1'b0, 1'b1, 32'h0000_0000, 2'b10},
        '{32'h0040_6010, 1'b1, 1'b0, 32'h0066_6010, 2'b00},
        '{32'h0081_2345, 1'b1, 1'b1, 32'h0C01_2345, 2'b00},
        '{32'h00C0_0000, 1'b0, 1'b0, 32'h0000_0000, 2'b01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_enable = 1'b1;
    logic [19:0] dir_frame = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_phys, fault_addr;

    logic        init_req = 1'b0;
    logic        log_clr = 1'b0;
    bit   [31:0] mem [bit [31:0]];
    int          rd_n = 0;
    int          wr_n = 0;
    logic [31:0] rd_log [4];

    int checks = 0;
    int errors = 0;

    logic [31:0] got_phys;
    logic        got_fault;
    logic [1:0]  got_cause;
    logic [31:0] got_faddr;
    bit          busy_ready;
    bit          long_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwalk_top u0 (
        .clk(clk), .rst_n(rst_n), .pg_enable(pg_enable), .dir_frame(dir_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_phys(rsp_phys), .fault_addr(fault_addr)
    );

    function automatic bit [31:0] peek(input bit [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (init_req) begin
            mem.delete();
            mem[32'h0001_0004] = 32'h0002_0007;
            mem[32'h0001_0008] = 32'h0C00_00A7;
            mem[32'h0001_000C] = 32'h0000_0000;
            mem[32'h0002_000C] = 32'h00AB_C007;
            mem[32'h0002_0010] = 32'h00DE_F000;
            mem[32'h0002_0014] = 32'h0055_5005;
            mem[32'h0002_0018] = 32'h0066_6003;
        end
        if (log_clr) begin
            rd_n = 0;
            wr_n = 0;
        end
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_n = wr_n + 1;
            end else begin
                mem_rdata <= peek(mem_addr);
                if (rd_n < 4) rd_log[rd_n] = mem_addr;
                rd_n = rd_n + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_mem();
        @(negedge clk);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic xlat(input logic [31:0] lin, input logic wr, input logic usr);
        int n;
        @(negedge clk);
        log_clr   = 1'b1;
        req_valid = 1'b1;
        req_lin   = lin;
        req_write = wr;
        req_user  = usr;
        @(negedge clk);
        log_clr    = 1'b0;
        req_valid  = 1'b0;
        busy_ready = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk);
            n++;
        end
        if (n >= 200) begin
            check(1'b0, "R9 walk timeout", 32'(n), 32'd0);
        end
        got_phys  = rsp_phys;
        got_fault = rsp_fault;
        got_cause = rsp_cause;
        got_faddr = fault_addr;
        @(negedge clk);
        long_pulse = rsp_valid;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R9 and R10
        check(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0 && mem_req == 1'b0, "R9 reset idle", {30'd0, rsp_valid, mem_req}, 32'd0);
        check(fault_addr == 32'h0, "R10 reset fault_addr", fault_addr, 32'h0);
        rst_n = 1'b1;
        load_mem();

        // vector table: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            xlat(VECS[i].lin, VECS[i].wr, VECS[i].usr);
            check(got_cause == VECS[i].cause && got_fault == (VECS[i].cause != 2'b00),
                  "R5/R6 vector cause", {29'd0, got_fault, got_cause}, {30'd0, VECS[i].cause});
            if (VECS[i].cause == 2'b00)
                check(got_phys == VECS[i].phys, "R3/R4 vector phys", got_phys, VECS[i].phys);
            else
                check(got_faddr == VECS[i].lin, "R5 vector fault_addr", got_faddr, VECS[i].lin);
            check(!busy_ready && !long_pulse, "R9 handshake", {30'd0, busy_ready, long_pulse}, 32'd0);
        end

        // accessed and dirty write-back on fresh tables
        load_mem();
        xlat(32'h0040_3123, 1'b0, 1'b1);
        check(rd_log[0] == 32'h0001_0004, "R2 directory entry address", rd_log[0], 32'h0001_0004);
        check(rd_log[1] == 32'h0002_000C, "R2 table entry address", rd_log[1], 32'h0002_000C);
        check(got_phys == 32'h00AB_C123, "R3 small page phys", got_phys, 32'h00AB_C123);
        check(wr_n == 2, "R7 two write-backs", 32'(wr_n), 32'd2);
        check(peek(32'h0001_0004) == 32'h0002_0027, "R7 directory accessed", peek(32'h0001_0004), 32'h0002_0027);
        check(peek(32'h0002_000C) == 32'h00AB_C027, "R8 read leaves dirty clear", peek(32'h0002_000C), 32'h00AB_C027);

        xlat(32'h0040_3123, 1'b0, 1'b1);
        check(wr_n == 0, "R7 no write when already set", 32'(wr_n), 32'd0);

        xlat(32'h0040_3123, 1'b1, 1'b0);
        check(wr_n == 1, "R8 one dirty write", 32'(wr_n), 32'd1);
        check(peek(32'h0002_000C) == 32'h00AB_C067, "R8 table dirty set", peek(32'h0002_000C), 32'h00AB_C067);
        check(peek(32'h0001_0004) == 32'h0002_0027, "R8 directory never dirty", peek(32'h0001_0004), 32'h0002_0027);

        xlat(32'h0081_2345, 1'b1, 1'b0);
        check(rd_n == 1, "R4 no table read", 32'(rd_n), 32'd1);
        check(wr_n == 0, "R8 large page no dirty write", 32'(wr_n), 32'd0);
        check(got_phys == 32'h0C01_2345, "R4 large page phys", got_phys, 32'h0C01_2345);

        // protection fault leaves entry alone
        xlat(32'h0040_5777, 1'b1, 1'b1);
        check(got_cause == 2'b10, "R6 write to read-only", {30'd0, got_cause}, 32'd2);
        check(peek(32'h0002_0014) == 32'h0055_5005, "R6 entry untouched", peek(32'h0002_0014), 32'h0055_5005);

        // fault address kept
        xlat(32'h00C0_0000, 1'b0, 1'b0);
        check(got_cause == 2'b01 && got_faddr == 32'h00C0_0000, "R5 not present", got_faddr, 32'h00C0_0000);
        check(wr_n == 0, "R7 no write on fault", 32'(wr_n), 32'd0);
        xlat(32'h0040_3123, 1'b0, 1'b0);
        check(fault_addr == 32'h00C0_0000, "R10 fault_addr kept", fault_addr, 32'h00C0_0000);

        // bypass
        pg_enable = 1'b0;
        xlat(32'hDEAD_BEEF, 1'b1, 1'b1);
        check(got_phys == 32'hDEAD_BEEF && !got_fault, "R1 bypass phys", got_phys, 32'hDEAD_BEEF);
        check(rd_n + wr_n == 0, "R1 no memory access", 32'(rd_n + wr_n), 32'd0);
        pg_enable = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule